// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between the processor of an 8-bit handheld system and its memories. It takes a 16-bit processor address with a read or write request and routes it to one target region: the fixed program ROM bank, the switchable program ROM window, video RAM, cartridge RAM or the cartridge clock registers, the low work RAM bank, the switchable work RAM bank, the sprite attribute table, the I/O registers, the high RAM, or the interrupt-enable register. For each access it gives a region code, the address local to that region, and a read or write strobe, all registered one cycle after the request.

The mirrored work RAM ranges, the ROM range that turns writes into commands for the cartridge bank controller, and the regions that may be closed (cartridge RAM with no enable, the sprite table while video is busy, the unusable gap) are all handled here. A read of a closed region returns 0xFF on the read data path, and a write to it produces no strobe. The block also holds the work RAM bank register, which it folds into the local address of the switchable bank.

Top module: `mmap_decoder`

## Requirements
- R1: A read with address bits [15:14] equal to 0 gives region code 1 (fixed ROM); with [15:14] equal to 1 it gives region code 2 (switchable ROM). Both carry local address = address bits [13:0].
- R2: A write to 0x0000–0x7FFF gives region code 12 (bank controller command) with a write strobe and local address = address bits [14:0]; no ROM region is written.
- R3: An access to 0x8000–0x9FFF gives region code 3 (video RAM) with local address = address bits [12:0].
- R4: In 0xA000–0xBFFF, clock enable high gives region code 5 (clock register, local address 0) whatever the RAM enable; otherwise RAM enable high gives region code 4 (cartridge RAM, local address = bits [12:0]); otherwise the region is closed.
- R5: The work RAM bank register resets to 1; a bank write loads the written value AND 7, and a result of 0 loads 1.
- R6: 0xC000–0xCFFF and 0xE000–0xEFFF give region code 6 with local address {3'b000, bits [11:0]}; 0xD000–0xDFFF and 0xF000–0xFDFF give region code 7 with local address {bank, bits [11:0]}, using the bank value held before any bank write in the same cycle.
- R7: 0xFE00–0xFE9F gives region code 8 (sprite table, local address bits [7:0]) only while the video mode input is 0 or 1; at mode 2 or 3 the region is closed.
- R8: 0xFEA0–0xFEFF is always closed.
- R9: 0xFF00–0xFF7F gives region code 9 (I/O), 0xFF80–0xFFFE gives region code 10 (high RAM), both with local address bits [6:0]; 0xFFFF gives region code 11 (interrupt enable) with local address 0.
- R10: A closed region gives region code 0 and no strobe; a read of it drives 0xFF on the read data output in the strobe cycle, while an open read passes the target's returned data.
- R11: Outputs appear one cycle after the request; with no request the region code is 0 and both strobes are low; when read and write are both requested the write wins; the write data output carries the registered write data.
- R12: After reset the region code is 0, both strobes are low and the bank output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_rdata | output | 8 | Read data returned to the processor |
| ext_ram_en | input | 1 | Cartridge RAM enabled by the bank controller |
| clock_reg_en | input | 1 | Cartridge clock register access enabled |
| vid_mode | input | 2 | Current video mode |
| bank_wr | input | 1 | Work RAM bank register write strobe |
| bank_wdata | input | 8 | Value written to the bank register |
| tgt_sel | output | 4 | Region code of the routed access |
| tgt_loc | output | 15 | Address local to the selected region |
| tgt_rd | output | 1 | Read strobe to the selected region |
| tgt_wr | output | 1 | Write strobe to the selected region |
| tgt_wdata | output | 8 | Write data to the selected region |
| tgt_rdata | input | 8 | Data returned by the selected region |
| wram_bank | output | 3 | Current work RAM bank |

## Verification
Directed accesses hit both sides of every region boundary (0x3FFF/0x4000, 0x7FFF/0x8000, 0xFDFF/0xFE00, 0xFE9F/0xFEA0, 0xFEFF/0xFF00, 0xFF7F/0xFF80, 0xFFFE/0xFFFF), which separates an off-by-one in a boundary from a wrong region code. Cartridge RAM is tried with all four enable combinations and the sprite table under each video mode, telling the clock override and the mode gate apart from the plain closed case. Bank writes of 0, 8 and values with high bits set show the masking and the zero-to-one rule, and a bank write in the same cycle as a switchable-bank access shows which bank value is used. Random addresses biased toward the top page, with random enables, modes and simultaneous read and write requests, cover the combinations the directed cases miss.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  localparam int ADDR_W = 16;
  localparam int LOC_W  = 15;

  typedef enum logic [3:0] {
    RGN_NONE    = 4'd0,
    RGN_ROM_FIX = 4'd1,
    RGN_ROM_SW  = 4'd2,
    RGN_VRAM    = 4'd3,
    RGN_XRAM    = 4'd4,
    RGN_CLOCK   = 4'd5,
    RGN_WRAM_LO = 4'd6,
    RGN_WRAM_SW = 4'd7,
    RGN_SPRITE  = 4'd8,
    RGN_IO      = 4'd9,
    RGN_HRAM    = 4'd10,
    RGN_IE      = 4'd11,
    RGN_BANKCTL = 4'd12
  } region_e;

  typedef struct packed {
    region_e          sel;
    logic [LOC_W-1:0] loc;
    logic             rd;
    logic             wr;
    logic             closed_rd;
  } route_t;

endpackage

// File: rtl/mmap_wram_bank.sv
module mmap_wram_bank #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank
);

  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  logic [BANK_W-1:0] masked;
  logic [BANK_W-1:0] bank_nxt;

  always_comb begin
    masked   = wdata[BANK_W-1:0];
    bank_nxt = (masked == '0) ? BANK_ONE : masked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= BANK_ONE;
    end else if (wr_en) begin
      bank <= bank_nxt;
    end
  end

endmodule

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
  import mmap_pkg::*;
#(
  parameter int                SPRITE_MODE_W   = 2,
  parameter int                SPRITE_MODE_MAX = 2,
  parameter int                BANK_W          = 3,
  parameter logic [ADDR_W-1:0] SPRITE_BASE     = 16'hFE00,
  parameter logic [ADDR_W-1:0] GAP_BASE        = 16'hFEA0,
  parameter logic [ADDR_W-1:0] IO_BASE         = 16'hFF00,
  parameter logic [ADDR_W-1:0] HRAM_BASE       = 16'hFF80,
  parameter logic [ADDR_W-1:0] IE_ADDR         = 16'hFFFF
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rd,
  input  logic                     wr,
  input  logic                     xram_en,
  input  logic                     clock_en,
  input  logic [SPRITE_MODE_W-1:0] mode,
  input  logic [BANK_W-1:0]        bank,
  output route_t                   route
);

  localparam int PAGE_OFF_W = 12;
  localparam int ROM_OFF_W  = 14;
  localparam int VRAM_OFF_W = 13;
  localparam int SPR_OFF_W  = 8;
  localparam int TOP_OFF_W  = 7;

  logic    is_wr;
  logic    is_rd;
  logic    open_hit;
  logic    sprite_open;
  region_e hit_sel;
  logic [LOC_W-1:0] hit_loc;

  always_comb begin
    is_wr       = wr;
    is_rd       = rd & ~wr;
    sprite_open = (int'(mode) < SPRITE_MODE_MAX);
    open_hit    = 1'b0;
    hit_sel     = RGN_NONE;
    hit_loc     = '0;

    unique case (addr[ADDR_W-1:ADDR_W-4])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        open_hit = 1'b1;
        if (is_wr) begin
          hit_sel = RGN_BANKCTL;
          hit_loc = LOC_W'(addr[LOC_W-1:0]);
        end else begin
          hit_sel = RGN_ROM_FIX;
          hit_loc = LOC_W'(addr[ROM_OFF_W-1:0]);
        end
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        open_hit = 1'b1;
        if (is_wr) begin
          hit_sel = RGN_BANKCTL;
          hit_loc = LOC_W'(addr[LOC_W-1:0]);
        end else begin
          hit_sel = RGN_ROM_SW;
          hit_loc = LOC_W'(addr[ROM_OFF_W-1:0]);
        end
      end
      4'h8, 4'h9: begin
        open_hit = 1'b1;
        hit_sel  = RGN_VRAM;
        hit_loc  = LOC_W'(addr[VRAM_OFF_W-1:0]);
      end
      4'hA, 4'hB: begin
        if (clock_en) begin
          open_hit = 1'b1;
          hit_sel  = RGN_CLOCK;
          hit_loc  = '0;
        end else if (xram_en) begin
          open_hit = 1'b1;
          hit_sel  = RGN_XRAM;
          hit_loc  = LOC_W'(addr[VRAM_OFF_W-1:0]);
        end
      end
      4'hC, 4'hE: begin
        open_hit = 1'b1;
        hit_sel  = RGN_WRAM_LO;
        hit_loc  = LOC_W'(addr[PAGE_OFF_W-1:0]);
      end
      4'hD: begin
        open_hit = 1'b1;
        hit_sel  = RGN_WRAM_SW;
        hit_loc  = LOC_W'({bank, addr[PAGE_OFF_W-1:0]});
      end
      default: begin
        if (addr < SPRITE_BASE) begin
          open_hit = 1'b1;
          hit_sel  = RGN_WRAM_SW;
          hit_loc  = LOC_W'({bank, addr[PAGE_OFF_W-1:0]});
        end else if (addr < GAP_BASE) begin
          if (sprite_open) begin
            open_hit = 1'b1;
            hit_sel  = RGN_SPRITE;
            hit_loc  = LOC_W'(addr[SPR_OFF_W-1:0]);
          end
        end else if (addr < IO_BASE) begin
          open_hit = 1'b0;
        end else if (addr < HRAM_BASE) begin
          open_hit = 1'b1;
          hit_sel  = RGN_IO;
          hit_loc  = LOC_W'(addr[TOP_OFF_W-1:0]);
        end else if (addr < IE_ADDR) begin
          open_hit = 1'b1;
          hit_sel  = RGN_HRAM;
          hit_loc  = LOC_W'(addr[TOP_OFF_W-1:0]);
        end else begin
          open_hit = 1'b1;
          hit_sel  = RGN_IE;
          hit_loc  = '0;
        end
      end
    endcase

    route           = '0;
    route.sel       = RGN_NONE;
    if (is_rd || is_wr) begin
      if (open_hit) begin
        route.sel = hit_sel;
        route.loc = hit_loc;
        route.rd  = is_rd;
        route.wr  = is_wr;
      end else begin
        route.closed_rd = is_rd;
      end
    end
  end

endmodule

// File: rtl/mmap_out_reg.sv
module mmap_out_reg
  import mmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  route_t            route_d,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic [DATA_W-1:0] tgt_rdata,
  output route_t            route_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] cpu_rdata
);

  localparam logic [DATA_W-1:0] OPEN_BUS = {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q     <= '0;
      route_q.sel <= RGN_NONE;
      wdata_q     <= '0;
    end else begin
      route_q <= route_d;
      wdata_q <= wdata_d;
    end
  end

  assign cpu_rdata = route_q.closed_rd ? OPEN_BUS : tgt_rdata;

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int                DATA_W          = 8,
  parameter int                BANK_W          = 3,
  parameter int                MODE_W          = 2,
  parameter int                SPRITE_MODE_MAX = 2,
  parameter logic [ADDR_W-1:0] SPRITE_BASE     = 16'hFE00,
  parameter logic [ADDR_W-1:0] GAP_BASE        = 16'hFEA0,
  parameter logic [ADDR_W-1:0] IO_BASE         = 16'hFF00,
  parameter logic [ADDR_W-1:0] HRAM_BASE       = 16'hFF80,
  parameter logic [ADDR_W-1:0] IE_ADDR         = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ext_ram_en,
  input  logic              clock_reg_en,
  input  logic [MODE_W-1:0] vid_mode,
  input  logic              bank_wr,
  input  logic [DATA_W-1:0] bank_wdata,
  output logic [3:0]        tgt_sel,
  output logic [14:0]       tgt_loc,
  output logic              tgt_rd,
  output logic              tgt_wr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic [DATA_W-1:0] tgt_rdata,
  output logic [BANK_W-1:0] wram_bank
);

  route_t route_d;
  route_t route_q;

  mmap_wram_bank #(
    .DATA_W(DATA_W),
    .BANK_W(BANK_W)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .wr_en(bank_wr),
    .wdata(bank_wdata),
    .bank (wram_bank)
  );

  mmap_region_decode #(
    .SPRITE_MODE_W  (MODE_W),
    .SPRITE_MODE_MAX(SPRITE_MODE_MAX),
    .BANK_W         (BANK_W),
    .SPRITE_BASE    (SPRITE_BASE),
    .GAP_BASE       (GAP_BASE),
    .IO_BASE        (IO_BASE),
    .HRAM_BASE      (HRAM_BASE),
    .IE_ADDR        (IE_ADDR)
  ) u_dec (
    .addr    (cpu_addr),
    .rd      (cpu_rd),
    .wr      (cpu_wr),
    .xram_en (ext_ram_en),
    .clock_en(clock_reg_en),
    .mode    (vid_mode),
    .bank    (wram_bank),
    .route   (route_d)
  );

  mmap_out_reg #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .route_d  (route_d),
    .wdata_d  (cpu_wdata),
    .tgt_rdata(tgt_rdata),
    .route_q  (route_q),
    .wdata_q  (tgt_wdata),
    .cpu_rdata(cpu_rdata)
  );

  assign tgt_sel = route_q.sel;
  assign tgt_loc = route_q.loc;
  assign tgt_rd  = route_q.rd;
  assign tgt_wr  = route_q.wr;

endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic [1:0]  vid_mode,
  input logic        bank_wr,
  input logic [7:0]  bank_wdata,
  input logic [3:0]  tgt_sel,
  input logic        tgt_rd,
  input logic        tgt_wr,
  input logic [2:0]  wram_bank
);

  AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    wram_bank != 3'd0); // R5

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bank_wr && bank_wdata[2:0] != 3'd0) |=> wram_bank == $past(bank_wdata[2:0])); // R5

  AST_BANK_ZERO_TO_ONE: assert property (@(posedge clk) disable iff (rst)
    (bank_wr && bank_wdata[2:0] == 3'd0) |=> wram_bank == 3'd1); // R5

  AST_ROM_WRITE_CMD: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_addr[15]) |=> (tgt_sel == 4'd12 && tgt_wr && !tgt_rd)); // R2

  AST_SPRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    ((cpu_rd || cpu_wr) && cpu_addr >= 16'hFE00 && cpu_addr < 16'hFEA0 && vid_mode >= 2'd2)
    |=> (!tgt_rd && !tgt_wr)); // R7

  AST_GAP_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr >= 16'hFEA0 && cpu_addr < 16'hFF00)
    |=> (cpu_rdata == 8'hFF && !tgt_rd)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |=> (!tgt_rd && !tgt_wr && tgt_sel == 4'd0)); // R11

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(tgt_rd && tgt_wr)); // R11

endmodule

bind mmap_decoder mmap_decoder_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .vid_mode  (vid_mode),
  .bank_wr   (bank_wr),
  .bank_wdata(bank_wdata),
  .tgt_sel   (tgt_sel),
  .tgt_rd    (tgt_rd),
  .tgt_wr    (tgt_wr),
  .wram_bank (wram_bank)
);

// File: tb/mmap_decoder_test.sv
`timescale 1ns/1ps
module mmap_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        ext_ram_en = 1'b0;
  logic        clock_reg_en = 1'b0;
  logic [1:0]  vid_mode = '0;
  logic        bank_wr = 1'b0;
  logic [7:0]  bank_wdata = '0;
  logic [3:0]  tgt_sel;
  logic [14:0] tgt_loc;
  logic        tgt_rd;
  logic        tgt_wr;
  logic [7:0]  tgt_wdata;
  logic [7:0]  tgt_rdata = '0;
  logic [2:0]  wram_bank;

  int errors = 0;
  int checks = 0;
  logic [2:0] m_bank = 3'd1;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmap_decoder uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .ext_ram_en(ext_ram_en), .clock_reg_en(clock_reg_en), .vid_mode(vid_mode),
    .bank_wr(bank_wr), .bank_wdata(bank_wdata), .tgt_sel(tgt_sel),
    .tgt_loc(tgt_loc), .tgt_rd(tgt_rd), .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata), .wram_bank(wram_bank)
  );

  // Expected {sel[3:0], loc[14:0], rd, wr, closed_read}
  function automatic logic [21:0] exp_route(input logic [15:0] a, input logic rd,
      input logic wr, input logic xen, input logic cen, input logic [1:0] md,
      input logic [2:0] bk);
    logic [3:0] s; logic [14:0] l; logic open; logic r; logic w;
    s = 4'd0; l = '0; open = 1'b1;
    w = wr; r = rd & ~wr;
    if (a < 16'h8000) begin
      if (w) begin s = 4'd12; l = a[14:0]; end                           // R2
      else begin s = (a < 16'h4000) ? 4'd1 : 4'd2; l = {1'b0, a[13:0]}; end // R1
    end else if (a < 16'hA000) begin s = 4'd3; l = {2'b0, a[12:0]}; end      // R3
    else if (a < 16'hC000) begin                                             // R4
      if (cen) begin s = 4'd5; l = '0; end
      else if (xen) begin s = 4'd4; l = {2'b0, a[12:0]}; end
      else open = 1'b0;
    end else if (a < 16'hD000 || (a >= 16'hE000 && a < 16'hF000)) begin       // R6
      s = 4'd6; l = {3'b0, a[11:0]};
    end else if (a < 16'hFE00) begin s = 4'd7; l = {bk, a[11:0]}; end
    else if (a < 16'hFEA0) begin                                             // R7
      if (md < 2'd2) begin s = 4'd8; l = {7'b0, a[7:0]}; end else open = 1'b0;
    end else if (a < 16'hFF00) open = 1'b0;                                  // R8
    else if (a < 16'hFF80) begin s = 4'd9; l = {8'b0, a[6:0]}; end           // R9
    else if (a < 16'hFFFF) begin s = 4'd10; l = {8'b0, a[6:0]}; end
    else begin s = 4'd11; l = '0; end
    if (!(r || w)) return '0;                                                // R11
    if (!open) return {4'd0, 15'd0, 1'b0, 1'b0, r};                          // R10
    return {s, l, r, w, 1'b0};
  endfunction

  function automatic string req_of(input logic [15:0] a, input logic rd, input logic wr);
    if (!(rd || wr)) return "R11";
    if (a < 16'h8000) return wr ? "R2" : "R1";
    if (a < 16'hA000) return "R3";
    if (a < 16'hC000) return "R4";
    if (a < 16'hFE00) return "R6";
    if (a < 16'hFEA0) return "R7";
    if (a < 16'hFF00) return "R8";
    return "R9";
  endfunction

  task automatic access(input logic [15:0] a, input logic rd, input logic wr,
      input logic xen, input logic cen, input logic [1:0] md,
      input logic bw, input logic [7:0] bd);
    logic [21:0] e; logic [21:0] act; logic [7:0] wd; logic [7:0] td;
    logic [7:0] exp_rdata; logic [2:0] nb;
    wd = 8'($urandom); td = 8'($urandom);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    ext_ram_en = xen; clock_reg_en = cen; vid_mode = md;
    bank_wr = bw; bank_wdata = bd; tgt_rdata = td;
    e = exp_route(a, rd, wr, xen, cen, md, m_bank);
    if (bw) begin nb = bd[2:0]; m_bank = (nb == 3'd0) ? 3'd1 : nb; end
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0; bank_wr = 1'b0;
    act = {tgt_sel, tgt_loc, tgt_rd, tgt_wr, 1'b0};
    exp_rdata = e[0] ? 8'hFF : td;
    checks++;
    if (act[21:1] != e[21:1] || cpu_rdata != exp_rdata || (e[1] && tgt_wdata != wd)) begin
      errors++;
      $display("FAIL %s addr=%h rd=%b wr=%b: sel/loc/rd/wr=%h rdata=%h wdata=%h, expected %h rdata=%h wdata=%h",
               req_of(a, rd, wr), a, rd, wr, act[21:1], cpu_rdata, tgt_wdata,
               e[21:1], exp_rdata, wd);
    end
    checks++;
    if (wram_bank != m_bank) begin
      errors++;
      $display("FAIL R5 bank after write=%b data=%h: got %0d expected %0d", bw, bd, wram_bank, m_bank);
    end
  endtask

  task automatic rd_at(input logic [15:0] a);
    access(a, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic wr_at(input logic [15:0] a);
    access(a, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  initial begin
    process::self().srandom(32'h5EED_0017);
    repeat (4) @(negedge clk);
    // R12: reset state
    checks++;
    if (tgt_sel != 4'd0 || tgt_rd || tgt_wr || wram_bank != 3'd1) begin
      errors++;
      $display("FAIL R12 reset: sel=%0d rd=%b wr=%b bank=%0d expected 0 0 0 1",
               tgt_sel, tgt_rd, tgt_wr, wram_bank);
    end
    rst = 1'b0;
    @(negedge clk);

    // R1 / R2 ROM boundaries and bank controller writes
    rd_at(16'h0000); rd_at(16'h3FFF); rd_at(16'h4000); rd_at(16'h7FFF);
    wr_at(16'h0000); wr_at(16'h2100); wr_at(16'h7FFF);
    // R3
    rd_at(16'h8000); wr_at(16'h9FFF);
    // R4 all enable combinations
    for (int k = 0; k < 4; k++) begin
      access(16'hA123, 1'b1, 1'b0, k[0], k[1], 2'd0, 1'b0, 8'h00);
      access(16'hBFFF, 1'b0, 1'b1, k[0], k[1], 2'd0, 1'b0, 8'h00);
    end
    // R5 bank rule: 0 -> 1, masking of upper bits, 8 -> 1
    access(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'h00);
    access(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'h0D);
    rd_at(16'hD456);
    access(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'h08);
    access(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'hF7);
    // R6 mirrors and same-cycle bank write uses old bank
    rd_at(16'hC123); rd_at(16'hE123); wr_at(16'hCFFF); wr_at(16'hEFFF);
    access(16'hD010, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'h02);
    rd_at(16'hD010); rd_at(16'hF456); wr_at(16'hFDFF);
    // R7 sprite table under each mode
    for (int m = 0; m < 4; m++) begin
      access(16'hFE00, 1'b1, 1'b0, 1'b0, 1'b0, m[1:0], 1'b0, 8'h00);
      access(16'hFE9F, 1'b0, 1'b1, 1'b0, 1'b0, m[1:0], 1'b0, 8'h00);
    end
    // R8 gap
    rd_at(16'hFEA0); wr_at(16'hFEA0); rd_at(16'hFEFF);
    // R9 top page
    rd_at(16'hFF00); rd_at(16'hFF7F); wr_at(16'hFF80); rd_at(16'hFFFE);
    rd_at(16'hFFFF); wr_at(16'hFFFF);
    // R11 idle and read+write together
    access(16'hC000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    access(16'hFF90, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    access(16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);

    // Constrained random
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a; logic [3:0] op;
      a = 16'($urandom);
      if ($urandom_range(0, 1) == 0) a[15:9] = 7'h7F;
      op = 4'($urandom);
      access(a, op[0], op[1] & op[2], 1'($urandom), 1'($urandom),
             2'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule